// File: doc/BRIEF.md
# One-Shot Event Timer with Interrupt

This block is a memory-mapped countdown timer for generating single timed events. Software writes a start value into a divisor register. It then issues a load operation, which copies that value into the down-counter, and a run operation, which starts the count. The counter steps down once per tick. When it reaches zero it raises a pending flag and stays at zero until the next load. A hold operation freezes the count, and that is how the timer is stopped. The current count is readable, so the time elapsed since run is (divisor − count) ticks. At the full rate one tick is one clock, which is 10 ns with a 100 MHz core clock.

The pending flag is visible in a raw status register. It is gated by a one-bit enable in a mask register, and the gated result appears in a masked status register and on a level-sensitive interrupt line. Writing a 1 to an acknowledge register clears the flag. A separate free-running up-counter advances every clock from reset, wraps at its width and serves as a timestamp. Access uses a simple port made of a valid strobe, a write flag, a word address and 32-bit data. Writes take effect on the clock edge where valid is high, and read data is combinational from the address.

Top module: `event_timer`

## Requirements
- R1: After reset the divisor, control, count, mask, raw status, masked status and acknowledge registers all read 0 and `irq` is low.
- R2: Word addresses: 0 divisor (read/write), 1 control (read/write, op in bits [1:0], rate in bits [3:2], other bits read 0), 2 count (read-only), 3 timestamp (read-only), 4 mask (bit 0, other bits read 0), 5 acknowledge (reads 0), 6 raw status (bit 0), 7 masked status (bit 0).
- R3: Writing control with op = 1 (load) copies the divisor into the count at that write's clock edge, and the count then stays put while op is load.
- R4: With op = 2 (run) and rate = 0 the count falls by one on every clock after the run write, so D clocks after a run from D it reaches 0 and the raw pending bit sets on that same edge.
- R5: Once the count is 0 it stays at 0 and sets no new pending bit until a load, even if run is written again.
- R6: Op = 0 (hold) or op = 3 freezes the count, and a later run continues from the frozen value.
- R7: Writing the divisor while the timer runs does not change the count; the new value is used only at the next load.
- R8: With rate = 1 the count falls once every SLOW_DIV clocks, the first step SLOW_DIV clocks after the control write.
- R9: With rate = 2 or 3 the count does not move even with op = run.
- R10: The masked status bit and the level `irq` output equal the raw pending bit AND mask bit 0; raw status shows pending regardless of the mask.
- R11: Writing acknowledge with bit 0 = 1 clears pending and writing it with bit 0 = 0 leaves pending alone. An expiry on the same edge as an acknowledge leaves pending set.
- R12: The timestamp increments by one on every clock whatever the timer does, and wraps to 0 after 2^TIME_W − 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock; one full-rate tick per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | Register access strobe |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Register word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr` |
| irq | output | 1 | Level interrupt, pending AND enable |

## Verification
The countdown is swept over every start value from 2 to 160 at full rate. Each run checks the count one clock before expiry, at expiry and after expiry, which separates off-by-one errors in the decrement from errors in the pending set and the stop at zero. A maximum-size start value and directed patterns cover the rest. These patterns are hold and resume, the spare op code, a divisor rewrite mid-run, the slow rate and the disabled rates, and an acknowledge landing on the expiry edge. Each of them tells apart behaviour that a plain countdown would get wrong. A second instance with an 8-bit timestamp shows the wrap.

// File: rtl/event_timer_pkg.sv
package event_timer_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_RUN   = 2'd2,
    OP_SPARE = 2'd3
  } tmrOp_e;

  typedef enum logic [1:0] {
    RATE_FULL = 2'd0,
    RATE_SLOW = 2'd1,
    RATE_OFFA = 2'd2,
    RATE_OFFB = 2'd3
  } tmrRate_e;

  localparam int REG_DIV    = 0;
  localparam int REG_CTRL   = 1;
  localparam int REG_COUNT  = 2;
  localparam int REG_TIME   = 3;
  localparam int REG_MASK   = 4;
  localparam int REG_ACK    = 5;
  localparam int REG_RAW    = 6;
  localparam int REG_MASKED = 7;

  typedef struct packed {
    logic load;
    logic tick;
    logic ack;
  } tmrStrobe_t;
endpackage

// File: rtl/event_timer_ctrl.sv
module event_timer_ctrl
  import event_timer_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int CNT_W    = 32,
  parameter int TIME_W   = 32,
  parameter int SLOW_DIV = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [CNT_W-1:0]  countVal,
  input  logic [TIME_W-1:0] timeVal,
  input  logic              pendVal,
  output tmrStrobe_t        strobe,
  output logic [CNT_W-1:0]  divisorVal,
  output logic              maskBit,
  output logic [DATA_W-1:0] busRdata
);
  logic     wrEn;
  logic     ctrlWr;
  tmrOp_e   opQ;
  tmrRate_e rateQ;
  logic     running;
  logic     slowTick;

  assign wrEn   = busValid & busWrite;
  assign ctrlWr = wrEn & (busAddr == ADDR_W'(REG_CTRL));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divisorVal <= '0;
      opQ        <= OP_HOLD;
      rateQ      <= RATE_FULL;
      maskBit    <= 1'b0;
    end else if (wrEn) begin
      if (busAddr == ADDR_W'(REG_DIV))  divisorVal <= busWdata[CNT_W-1:0];
      if (busAddr == ADDR_W'(REG_MASK)) maskBit    <= busWdata[0];
      if (ctrlWr) begin
        opQ   <= tmrOp_e'(busWdata[1:0]);
        rateQ <= tmrRate_e'(busWdata[3:2]);
      end
    end
  end

  assign running = (opQ == OP_RUN);

  generate
    if (SLOW_DIV > 1) begin : g_pre
      localparam int PRE_W = $clog2(SLOW_DIV);
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(SLOW_DIV - 1);
      logic [PRE_W-1:0] preQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                             preQ <= '0;
        else if (ctrlWr)                       preQ <= '0;
        else if (running && rateQ == RATE_SLOW) preQ <= (preQ == PRE_LAST) ? '0 : preQ + PRE_W'(1);
      end
      assign slowTick = (preQ == PRE_LAST);
    end else begin : g_nopre
      assign slowTick = 1'b1;
    end
  endgenerate

  always_comb begin
    strobe.load = ctrlWr & (busWdata[1:0] == OP_LOAD);
    strobe.tick = running & ((rateQ == RATE_FULL) | ((rateQ == RATE_SLOW) & slowTick));
    strobe.ack  = wrEn & (busAddr == ADDR_W'(REG_ACK)) & busWdata[0];
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADDR_W'(REG_DIV):    busRdata = DATA_W'(divisorVal);
      ADDR_W'(REG_CTRL):   busRdata = DATA_W'({rateQ, opQ});
      ADDR_W'(REG_COUNT):  busRdata = DATA_W'(countVal);
      ADDR_W'(REG_TIME):   busRdata = DATA_W'(timeVal);
      ADDR_W'(REG_MASK):   busRdata = DATA_W'(maskBit);
      ADDR_W'(REG_RAW):    busRdata = DATA_W'(pendVal);
      ADDR_W'(REG_MASKED): busRdata = DATA_W'(pendVal & maskBit);
      default:             busRdata = '0;
    endcase
  end

  p_off_rate_still_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rateQ == RATE_OFFA || rateQ == RATE_OFFB) |-> !strobe.tick);
endmodule

// File: rtl/event_timer_dp.sv
module event_timer_dp
  import event_timer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int TIME_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrStrobe_t        strobe,
  input  logic [CNT_W-1:0]  divisorVal,
  output logic [CNT_W-1:0]  countQ,
  output logic [TIME_W-1:0] timeQ,
  output logic              pendQ
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic expire;
  assign expire = strobe.tick & ~strobe.load & (countQ == CNT_ONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           countQ <= '0;
    else if (strobe.load)                countQ <= divisorVal;
    else if (strobe.tick && countQ != '0) countQ <= countQ - CNT_ONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           pendQ <= 1'b0;
    else if (expire)     pendQ <= 1'b1;
    else if (strobe.ack) pendQ <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) timeQ <= '0;
    else       timeQ <= timeQ + TIME_W'(1);
  end

  p_load_copy_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> countQ == $past(divisorVal));
  p_frozen_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.load && !strobe.tick) |=> $stable(countQ));
  p_zero_stays_r5: assert property (@(posedge clk) disable iff (!rstN)
    (countQ == '0 && !strobe.load) |=> (countQ == '0 && !$rose(pendQ)));
  p_expiry_pend_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tick && !strobe.load && countQ == CNT_ONE) |=> (pendQ && countQ == '0));
  p_ack_clears_r11: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ack && !(strobe.tick && !strobe.load && countQ == CNT_ONE)) |=> !pendQ);
  p_time_step_r12: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> timeQ == $past(timeQ) + TIME_W'(1));
endmodule

// File: rtl/event_timer.sv
module event_timer
  import event_timer_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int CNT_W    = 32,
  parameter int TIME_W   = 32,
  parameter int SLOW_DIV = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              irq
);
  tmrStrobe_t        strobe;
  logic [CNT_W-1:0]  divisorVal;
  logic [CNT_W-1:0]  countVal;
  logic [TIME_W-1:0] timeVal;
  logic              pendVal;
  logic              maskBit;

  event_timer_ctrl #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .TIME_W(TIME_W), .SLOW_DIV(SLOW_DIV)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .countVal(countVal),
    .timeVal(timeVal), .pendVal(pendVal), .strobe(strobe),
    .divisorVal(divisorVal), .maskBit(maskBit), .busRdata(busRdata)
  );

  event_timer_dp #(.CNT_W(CNT_W), .TIME_W(TIME_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .divisorVal(divisorVal),
    .countQ(countVal), .timeQ(timeVal), .pendQ(pendVal)
  );

  assign irq = pendVal & maskBit;

  p_irq_mask_r10: assert property (@(posedge clk) disable iff (!rstN)
    !maskBit |-> !irq);
endmodule

// File: tb/event_timer_bench.sv
module event_timer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irq;
  logic [31:0] smallRdata;
  logic        smallIrq;
  int total = 0;
  int bad = 0;
  bit done = 0;

  localparam logic [2:0] A_DIV = 0, A_CTRL = 1, A_CNT = 2, A_TIME = 3,
                         A_MASK = 4, A_ACK = 5, A_RAW = 6, A_MSKD = 7;

  always #10 clk = ~clk;

  event_timer u_event_timer (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  event_timer #(.CNT_W(8), .TIME_W(8)) u_small (
    .clk(clk), .rstN(rstN), .busValid(1'b0), .busWrite(1'b0),
    .busAddr(3'd3), .busWdata(32'd0), .busRdata(smallRdata), .irq(smallIrq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWrite = 1'b1; busValid = 1'b1;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    busAddr = a; busWrite = 1'b0; busValid = 1'b1;
    #1 d = busRdata;
    busValid = 1'b0;
  endtask

  task automatic rdchk(input string req, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic summary;
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v, t0, t1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rdchk("R1 div", A_DIV, 0);
    rdchk("R1 ctrl", A_CTRL, 0);
    rdchk("R1 count", A_CNT, 0);
    rdchk("R1 mask", A_MASK, 0);
    rdchk("R1 ack", A_ACK, 0);
    rdchk("R1 raw", A_RAW, 0);
    rdchk("R1 masked", A_MSKD, 0);
    chk("R1 irq", {31'd0, irq}, 0);

    // R2 readback and field widths
    wr(A_DIV, 32'hA5A5_1234);
    rdchk("R2 div", A_DIV, 32'hA5A5_1234);
    wr(A_CTRL, 32'h0000_00F8);
    rdchk("R2 ctrl", A_CTRL, 32'h8);
    wr(A_MASK, 32'hFFFF_FFFE);
    rdchk("R2 mask bit0", A_MASK, 0);
    wr(A_MASK, 32'hFFFF_FFFF);
    rdchk("R2 mask", A_MASK, 1);
    wr(A_CTRL, 0);

    // R3 load holds value
    wr(A_DIV, 32'hFFFF_FFFF);
    wr(A_CTRL, 1);
    rdchk("R3 load max", A_CNT, 32'hFFFF_FFFF);
    repeat (4) @(negedge clk);
    rdchk("R3 still", A_CNT, 32'hFFFF_FFFF);
    wr(A_CTRL, 2);
    repeat (5) @(negedge clk);
    rdchk("R4 elapsed max", A_CNT, 32'hFFFF_FFFA);
    wr(A_CTRL, 0);

    // R4 sweep of start values at full rate, mask on
    for (int d = 2; d <= 160; d++) begin
      wr(A_DIV, d);
      wr(A_CTRL, 1);
      rdchk("R3 sweep load", A_CNT, d);
      wr(A_CTRL, 2);
      repeat (d - 1) @(negedge clk);
      rdchk("R4 before expiry", A_CNT, 1);
      chk("R4 irq before", {31'd0, irq}, 0);
      @(negedge clk);
      rdchk("R4 at expiry", A_CNT, 0);
      rdchk("R4 raw", A_RAW, 1);
      rdchk("R10 masked", A_MSKD, 1);
      chk("R10 irq", {31'd0, irq}, 1);
      repeat (3) @(negedge clk);
      rdchk("R5 stays zero", A_CNT, 0);
      wr(A_ACK, 1);
      rdchk("R11 cleared", A_RAW, 0);
      chk("R11 irq low", {31'd0, irq}, 0);
    end

    // R5 run again from zero: no new pending
    wr(A_CTRL, 2);
    repeat (6) @(negedge clk);
    rdchk("R5 no repend", A_RAW, 0);
    rdchk("R5 count zero", A_CNT, 0);

    // R6 hold, spare op, resume
    wr(A_DIV, 100);
    wr(A_CTRL, 1);
    wr(A_CTRL, 2);
    repeat (10) @(negedge clk);
    rdchk("R4 mid", A_CNT, 90);
    wr(A_CTRL, 0);
    rdchk("R6 hold edge", A_CNT, 89);
    repeat (5) @(negedge clk);
    rdchk("R6 held", A_CNT, 89);
    wr(A_CTRL, 3);
    repeat (5) @(negedge clk);
    rdchk("R6 spare op held", A_CNT, 89);
    wr(A_CTRL, 2);
    repeat (4) @(negedge clk);
    rdchk("R6 resumed", A_CNT, 85);

    // R7 divisor rewrite mid-run
    wr(A_DIV, 50);
    wr(A_CTRL, 1);
    wr(A_CTRL, 2);
    repeat (3) @(negedge clk);
    wr(A_DIV, 7);
    rdchk("R7 unaffected", A_CNT, 46);
    wr(A_CTRL, 1);
    rdchk("R7 next load", A_CNT, 7);

    // R8 slow rate
    wr(A_DIV, 3);
    wr(A_CTRL, 1);
    wr(A_CTRL, 32'h6);
    repeat (3) @(negedge clk);
    rdchk("R8 before first step", A_CNT, 3);
    @(negedge clk);
    rdchk("R8 first step", A_CNT, 2);
    repeat (7) @(negedge clk);
    rdchk("R8 before expiry", A_CNT, 1);
    rdchk("R8 raw low", A_RAW, 0);
    @(negedge clk);
    rdchk("R8 expiry", A_CNT, 0);
    rdchk("R8 raw", A_RAW, 1);

    // R10 mask off
    wr(A_MASK, 0);
    rdchk("R10 raw unmasked", A_RAW, 1);
    rdchk("R10 masked off", A_MSKD, 0);
    chk("R10 irq off", {31'd0, irq}, 0);
    wr(A_MASK, 1);
    chk("R10 irq on", {31'd0, irq}, 1);
    // R11 write zero ignored
    wr(A_ACK, 0);
    rdchk("R11 ack zero", A_RAW, 1);
    wr(A_ACK, 1);
    rdchk("R11 ack one", A_RAW, 0);

    // R9 disabled rates
    wr(A_DIV, 5);
    wr(A_CTRL, 1);
    wr(A_CTRL, 32'hA);
    repeat (10) @(negedge clk);
    rdchk("R9 rate2", A_CNT, 5);
    wr(A_CTRL, 32'hE);
    repeat (10) @(negedge clk);
    rdchk("R9 rate3", A_CNT, 5);
    rdchk("R9 raw", A_RAW, 0);

    // R11 ack on expiry edge: set wins
    wr(A_DIV, 4);
    wr(A_CTRL, 1);
    wr(A_CTRL, 2);
    repeat (3) @(negedge clk);
    rdchk("R11 pre", A_CNT, 1);
    wr(A_ACK, 1);
    rdchk("R11 set wins", A_RAW, 1);
    wr(A_ACK, 1);
    rdchk("R11 later clear", A_RAW, 0);

    // R12 timestamp
    rd(A_TIME, t0);
    repeat (37) @(negedge clk);
    rd(A_TIME, t1);
    chk("R12 step", t1 - t0, 37);
    t0 = smallRdata;
    chk("R12 width", t0 & 32'hFFFF_FF00, 0);
    repeat (300) @(negedge clk);
    #1 v = smallRdata;
    chk("R12 wrap", v, (t0 + 300) & 32'hFF);

    done = 1;
    summary();
    $finish;
  end
endmodule